// File: doc/BRIEF.md
# Chained Debug Trigger Match Unit

This block holds a small bank of hardware debug triggers that sit beside a processor pipeline and watch its instruction fetches, loads and stores. Software or a debugger programs the triggers through a three-register window: a select register that picks one trigger, a control register for the picked trigger and a compare-value register for the picked trigger. All control and compare state lives in flops and changes only on a clock edge when a write is made.

Each cycle the pipeline offers one access: its operation kind, address, data, the current privilege level, a narrow-mode flag and a flag that says debug mode is active. The unit decides in the same cycle, with no register on the path, whether a trigger fires, which one, and the action code programmed into it. Each trigger can compare either the address or the data with one of six comparison rules, can be limited to particular operation kinds and privilege levels, and can be joined to its lower neighbour so that both must match together. Three registered flags tell the pipeline whether any armed trigger watches fetches, loads or stores, so that it can skip the check path when none does.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After reset the select register reads 0, every control register reads trigger type 2 in bits XLEN-1:XLEN-4 with all lower bits 0 (action 0), every compare register reads 0, no trigger fires and the three armed flags are 0.
- R2: Window addresses are 0 for select, 1 for control and 2 for compare; address 3 reads 0. Select reads back the full written value. A control write keeps bits 19:0 only (bit 0 load enable, bit 1 store enable, bit 2 execute enable, bits 6:3 privilege enables for levels 0 to 3, bits 10:7 compare rule, bit 11 chain, bits 18:12 action, bit 19 compare-data) and reads back with type 2 on top and a zero 6-bit range field below it. The compare register reads back its written value. Reads are combinational; writes take effect at the clock edge.
- R3: When the select register holds a value of 4 or more, control and compare writes change nothing and reads of those two addresses return 0.
- R4: A trigger never fires if its action is 0, if the enable for the access kind is clear (operation code 0 fetch, 1 load, 2 store, 3 matches nothing), or if the enable for the privilege level (input 0 to 3 selects enable bit 3 to 6) is clear.
- R5: With compare-data set the trigger compares the access data; with it clear it compares the access address.
- R6: Rule 0 fires on equality, rule 2 when the value is at least the compare value, rule 3 when it is below it (unsigned).
- R7: Rule 1 ignores as many low bits on both sides as there are trailing one bits in the compare value.
- R8: Rule 4 uses the upper half of the compare value as a mask and fires when masked value equals masked compare value; rule 5 does the same after shifting the value's upper half down. The half is XLEN/2 bits, or 16 bits in narrow mode.
- R9: A chained trigger can fire only if the trigger just below it matched; a match whose upper neighbour is chained does not fire alone; a non-matching trigger breaks the chain; trigger 0 with chain set never fires.
- R10: When several triggers or chains complete, the lowest completing index is reported with its action code.
- R11: Nothing fires while the request-valid input is low or debug mode is active.
- R12: In narrow mode the compared value is cut to its low 32 bits before comparison.
- R13: Each armed flag (fetch, load, store) is 1 when some trigger with nonzero action has the matching enable; the flags are updated at the clock edge of a control write and hold otherwise.
- R14: Compare rule codes 6 to 15 never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Register window write strobe |
| csr_sel | input | 2 | Window address: 0 select, 1 control, 2 compare |
| csr_wdata | input | XLEN | Window write data |
| csr_rdata | output | XLEN | Window read data for csr_sel |
| req_valid | input | 1 | Access request present |
| req_op | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_addr | input | XLEN | Access address |
| req_data | input | XLEN | Access data |
| req_priv | input | 2 | Privilege level 0 to 3 |
| req_narrow | input | 1 | 32-bit mode: truncate compared value |
| dbg_active | input | 1 | Debug mode active, suppresses all hits |
| hit_valid | output | 1 | A trigger fired this cycle |
| hit_index | output | 2 | Index of the firing trigger |
| hit_action | output | 7 | Action code of the firing trigger |
| arm_exec | output | 1 | Some armed trigger watches fetches |
| arm_load | output | 1 | Some armed trigger watches loads |
| arm_store | output | 1 | Some armed trigger watches stores |

## Verification
The match path has no storage, so a corrupted control or compare word shows on hit_valid, hit_index or hit_action at the first access that crosses the wrong rule, in the same cycle, and also on the window readback as soon as the same trigger is selected. A broken chain state shows as a hit reported at the lower half of a pair, or at a higher index than the lowest completing one. A stale armed flag is visible the cycle after the control write that should have changed it.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

    // access kinds presented by the pipeline
    localparam logic [1:0] OP_EXEC  = 2'd0;
    localparam logic [1:0] OP_LOAD  = 2'd1;
    localparam logic [1:0] OP_STORE = 2'd2;

    // window addresses
    localparam logic [1:0] WIN_SEL = 2'd0;
    localparam logic [1:0] WIN_CTL = 2'd1;
    localparam logic [1:0] WIN_CMP = 2'd2;

    // compare rules
    localparam logic [3:0] RULE_EQ   = 4'd0;
    localparam logic [3:0] RULE_POW2 = 4'd1;
    localparam logic [3:0] RULE_GE   = 4'd2;
    localparam logic [3:0] RULE_LT   = 4'd3;
    localparam logic [3:0] RULE_MLO  = 4'd4;
    localparam logic [3:0] RULE_MHI  = 4'd5;

    localparam int ACT_W = 7;
    localparam int CTL_W = 20;

    // stored control word, bit 19 down to bit 0
    typedef struct packed {
        logic             use_data;
        logic [ACT_W-1:0] action;
        logic             chain;
        logic [3:0]       rule;
        logic [3:0]       priv_en;
        logic             en_exec;
        logic             en_store;
        logic             en_load;
    } trig_ctl_t;

endpackage

// File: rtl/dbgtrig_regs.sv
module dbgtrig_regs
    import dbgtrig_pkg::*;
#(
    parameter int NUM_TRIG  = 4,
    parameter int XLEN      = 64,
    parameter int TRIG_TYPE = 2,
    parameter int MASKMAX   = 0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             csr_we,
    input  logic [1:0]                       csr_sel,
    input  logic [XLEN-1:0]                  csr_wdata,
    output logic [XLEN-1:0]                  csr_rdata,
    output trig_ctl_t [NUM_TRIG-1:0]         ctl_o,
    output logic [NUM_TRIG-1:0][XLEN-1:0]    cmp_o,
    output logic                             arm_exec,
    output logic                             arm_load,
    output logic                             arm_store
);

    localparam int IDX_W  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
    localparam int MM_LSB = XLEN - 10;

    typedef struct packed {
        logic [XLEN-1:0]                 sel;
        trig_ctl_t [NUM_TRIG-1:0]        ctl;
        logic [NUM_TRIG-1:0][XLEN-1:0]   cmp;
        logic                            arm_x;
        logic                            arm_l;
        logic                            arm_s;
    } regs_t;

    regs_t            st_d, st_q;
    logic             sel_ok;
    logic             ctl_wr;
    logic [IDX_W-1:0] idx;

    assign sel_ok = (st_q.sel < XLEN'(NUM_TRIG));
    assign idx    = st_q.sel[IDX_W-1:0];

    always_comb begin
        st_d   = st_q;
        ctl_wr = 1'b0;
        if (csr_we) begin
            case (csr_sel)
                WIN_SEL: st_d.sel = csr_wdata;
                WIN_CTL: if (sel_ok) begin
                    st_d.ctl[idx] = trig_ctl_t'(csr_wdata[CTL_W-1:0]);
                    ctl_wr        = 1'b1;
                end
                WIN_CMP: if (sel_ok) st_d.cmp[idx] = csr_wdata;
                default: ;
            endcase
        end
        if (ctl_wr) begin
            st_d.arm_x = 1'b0;
            st_d.arm_l = 1'b0;
            st_d.arm_s = 1'b0;
            for (int i = 0; i < NUM_TRIG; i++) begin
                if (st_d.ctl[i].action != '0) begin
                    st_d.arm_x = st_d.arm_x | st_d.ctl[i].en_exec;
                    st_d.arm_l = st_d.arm_l | st_d.ctl[i].en_load;
                    st_d.arm_s = st_d.arm_s | st_d.ctl[i].en_store;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_sel)
            WIN_SEL: csr_rdata = st_q.sel;
            WIN_CTL: if (sel_ok) begin
                csr_rdata[CTL_W-1:0]   = st_q.ctl[idx];
                csr_rdata[XLEN-1 -: 4] = 4'(TRIG_TYPE);
                csr_rdata[MM_LSB +: 6] = 6'(MASKMAX);
            end
            WIN_CMP: if (sel_ok) csr_rdata = st_q.cmp[idx];
            default: ;
        endcase
    end

    assign ctl_o     = st_q.ctl;
    assign cmp_o     = st_q.cmp;
    assign arm_exec  = st_q.arm_x;
    assign arm_load  = st_q.arm_l;
    assign arm_store = st_q.arm_s;

    // R3
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && (csr_sel != WIN_SEL) && !sel_ok) |=> ($stable(ctl_o) && $stable(cmp_o)));

    // R13
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && (csr_sel == WIN_CTL)) |=> $stable({arm_exec, arm_load, arm_store}));

endmodule

// File: rtl/dbgtrig_cmp.sv
module dbgtrig_cmp
    import dbgtrig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             use_data,
    input  logic             armed,
    input  logic [3:0]       rule,
    input  logic [3:0]       priv_en,
    input  logic             en_exec,
    input  logic             en_load,
    input  logic             en_store,
    input  logic [XLEN-1:0]  cmp_val,
    input  logic [1:0]       op,
    input  logic [1:0]       priv,
    input  logic             narrow,
    input  logic [XLEN-1:0]  addr,
    input  logic [XLEN-1:0]  data,
    output logic             pass
);

    localparam int HALF = XLEN / 2;

    logic            en_op;
    logic            hit;
    logic            run;
    int              sh;
    logic [XLEN-1:0] val, val_hi, half_mask, low_mask, keep;

    always_comb begin
        case (op)
            OP_EXEC:  en_op = en_exec;
            OP_LOAD:  en_op = en_load;
            OP_STORE: en_op = en_store;
            default:  en_op = 1'b0;
        endcase

        val = use_data ? data : addr;
        for (int j = 0; j < XLEN; j++) low_mask[j] = (j < 32);
        if (narrow) val = val & low_mask;

        // trailing ones of the compare value mark ignored bits
        run = 1'b1;
        for (int j = 0; j < XLEN; j++) begin
            run     = run & cmp_val[j];
            keep[j] = ~run;
        end

        sh        = narrow ? 16 : HALF;
        half_mask = cmp_val >> sh;
        val_hi    = val >> sh;

        case (rule)
            RULE_EQ:   hit = (val == cmp_val);
            RULE_POW2: hit = ((val & keep) == (cmp_val & keep));
            RULE_GE:   hit = (val >= cmp_val);
            RULE_LT:   hit = (val < cmp_val);
            RULE_MLO:  hit = ((val & half_mask) == (cmp_val & half_mask));
            RULE_MHI:  hit = ((val_hi & half_mask) == (cmp_val & half_mask));
            default:   hit = 1'b0;
        endcase

        pass = armed && en_op && priv_en[priv] && hit;
    end

endmodule

// File: rtl/dbgtrig_chain.sv
module dbgtrig_chain #(
    parameter int NUM_TRIG = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_TRIG-1:0] pass,
    input  logic [NUM_TRIG-1:0] chain,
    input  logic                active,
    output logic                fire,
    output logic [IDX_W-1:0]    fire_idx
);

    logic [NUM_TRIG-1:0] chain_up;
    logic                ok;
    logic                cand;

    // chain bit of the next trigger up, 0 past the top
    assign chain_up = {1'b0, chain[NUM_TRIG-1:1]};

    always_comb begin
        fire     = 1'b0;
        fire_idx = '0;
        ok       = 1'b0;
        cand     = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            cand = pass[i] && (!chain[i] || ok);
            if (cand) begin
                if (chain_up[i]) begin
                    ok = 1'b1;
                end else begin
                    ok = 1'b0;
                    if (!fire) begin
                        fire     = 1'b1;
                        fire_idx = IDX_W'(i);
                    end
                end
            end else begin
                ok = 1'b0;
            end
        end
        fire = fire && active;
    end

endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
    import dbgtrig_pkg::*;
#(
    parameter int NUM_TRIG  = 4,
    parameter int XLEN      = 64,
    parameter int TRIG_TYPE = 2,
    parameter int MASKMAX   = 0,
    localparam int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [1:0]       csr_sel,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [XLEN-1:0]  req_addr,
    input  logic [XLEN-1:0]  req_data,
    input  logic [1:0]       req_priv,
    input  logic             req_narrow,
    input  logic             dbg_active,
    output logic             hit_valid,
    output logic [IDX_W-1:0] hit_index,
    output logic [ACT_W-1:0] hit_action,
    output logic             arm_exec,
    output logic             arm_load,
    output logic             arm_store
);

    trig_ctl_t [NUM_TRIG-1:0]      ctl_q;
    logic [NUM_TRIG-1:0][XLEN-1:0] cmp_q;
    logic [NUM_TRIG-1:0]           pass_vec;
    logic [NUM_TRIG-1:0]           chain_vec;

    dbgtrig_regs #(
        .NUM_TRIG (NUM_TRIG),
        .XLEN     (XLEN),
        .TRIG_TYPE(TRIG_TYPE),
        .MASKMAX  (MASKMAX)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_we   (csr_we),
        .csr_sel  (csr_sel),
        .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .ctl_o    (ctl_q),
        .cmp_o    (cmp_q),
        .arm_exec (arm_exec),
        .arm_load (arm_load),
        .arm_store(arm_store)
    );

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_cmp
        assign chain_vec[g] = ctl_q[g].chain;
        dbgtrig_cmp #(.XLEN(XLEN)) cmp_i (
            .use_data(ctl_q[g].use_data),
            .armed   (ctl_q[g].action != '0),
            .rule    (ctl_q[g].rule),
            .priv_en (ctl_q[g].priv_en),
            .en_exec (ctl_q[g].en_exec),
            .en_load (ctl_q[g].en_load),
            .en_store(ctl_q[g].en_store),
            .cmp_val (cmp_q[g]),
            .op      (req_op),
            .priv    (req_priv),
            .narrow  (req_narrow),
            .addr    (req_addr),
            .data    (req_data),
            .pass    (pass_vec[g])
        );
    end

    dbgtrig_chain #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) chain_i (
        .pass    (pass_vec),
        .chain   (chain_vec),
        .active  (req_valid && !dbg_active),
        .fire    (hit_valid),
        .fire_idx(hit_index)
    );

    assign hit_action = hit_valid ? ctl_q[hit_index].action : '0;

    // R11
    hit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (req_valid && !dbg_active));

    // R4
    hit_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_action != '0));

    // R9
    chain_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && (int'(hit_index) < NUM_TRIG - 1)) |-> !ctl_q[int'(hit_index) + 1].chain);

    // R9
    chain_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && ctl_q[hit_index].chain) |-> (hit_index != '0));

endmodule

// File: tb/dbg_trigger_unit_tb_top.sv
module dbg_trigger_unit_tb_top;

    localparam int XLEN = 64;
    localparam logic [63:0] TYPE_BITS = 64'h2000_0000_0000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_we = 1'b0;
    logic [1:0]      csr_sel = 2'd0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            req_valid = 1'b0;
    logic [1:0]      req_op = 2'd0;
    logic [XLEN-1:0] req_addr = '0;
    logic [XLEN-1:0] req_data = '0;
    logic [1:0]      req_priv = 2'd3;
    logic            req_narrow = 1'b0;
    logic            dbg_active = 1'b0;
    logic            hit_valid;
    logic [1:0]      hit_index;
    logic [6:0]      hit_action;
    logic            arm_exec, arm_load, arm_store;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dbg_trigger_unit #(.NUM_TRIG(4), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_priv(req_priv), .req_narrow(req_narrow), .dbg_active(dbg_active),
        .hit_valid(hit_valid), .hit_index(hit_index), .hit_action(hit_action),
        .arm_exec(arm_exec), .arm_load(arm_load), .arm_store(arm_store)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input int act, input int rule, input bit chn,
                                       input bit dsel, input logic [3:0] pr,
                                       input bit x, input bit st, input bit ld);
        logic [63:0] v = '0;
        v[19] = dsel; v[18:12] = 7'(act); v[11] = chn; v[10:7] = 4'(rule);
        v[6:3] = pr; v[2] = x; v[1] = st; v[0] = ld;
        return v;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        @(negedge clk);
        csr_sel = a;
        #2 d = csr_rdata;
    endtask

    task automatic set_trig(input int i, input logic [63:0] c, input logic [63:0] v);
        wr(2'd0, 64'(i));
        wr(2'd2, v);
        wr(2'd1, c);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) set_trig(i, 64'd0, 64'd0);
    endtask

    task automatic req(input logic [1:0] op, input logic [63:0] a, input logic [63:0] d,
                       input logic [1:0] pr);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_priv = pr;
        #2;
    endtask

    task automatic chk_hit(input string tag, input bit v, input int idx, input int act);
        chk(tag, 64'(hit_valid), 64'(v));
        if (v) chk(tag, {55'd0, hit_index, hit_action}, {55'd0, 2'(idx), 7'(act)});
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd(2'd0, d); chk("R1 select", d, 0);
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, 64'(i));
            rd(2'd1, d); chk("R1 control", d, TYPE_BITS);
            rd(2'd2, d); chk("R1 compare", d, 0);
        end
        chk("R1 arm", {arm_exec, arm_load, arm_store}, 0);
        req(2'd0, 64'd0, 64'd0, 2'd3);
        chk_hit("R1 no hit", 0, 0, 0);
    endtask

    task automatic t_window();
        logic [63:0] d;
        wr(2'd0, 64'd1);
        rd(2'd0, d); chk("R2 select readback", d, 1);
        wr(2'd1, 64'hFFFF_FFFF_FFFA_5A5A);
        rd(2'd1, d); chk("R2 control readback", d, TYPE_BITS | 64'hA_5A5A);
        wr(2'd2, 64'h1234_5678_9ABC_DEF0);
        rd(2'd2, d); chk("R2 compare readback", d, 64'h1234_5678_9ABC_DEF0);
        rd(2'd3, d); chk("R2 unused address", d, 0);
        clear_all();
    endtask

    task automatic t_oob();
        logic [63:0] d;
        set_trig(0, mk(2, 0, 0, 0, 4'hF, 1, 0, 0), 64'h500);
        wr(2'd0, 64'd4);
        wr(2'd1, mk(3, 2, 0, 0, 4'hF, 1, 1, 1));
        wr(2'd2, 64'h77);
        rd(2'd0, d); chk("R3 select holds 4", d, 4);
        rd(2'd1, d); chk("R3 control reads 0", d, 0);
        rd(2'd2, d); chk("R3 compare reads 0", d, 0);
        wr(2'd0, 64'd0);
        rd(2'd1, d); chk("R3 trigger 0 control intact", d, TYPE_BITS | mk(2, 0, 0, 0, 4'hF, 1, 0, 0));
        rd(2'd2, d); chk("R3 trigger 0 compare intact", d, 64'h500);
        clear_all();
    endtask

    task automatic t_filter();
        set_trig(0, mk(2, 0, 0, 0, 4'hF, 1, 0, 0), 64'h1000);
        req(2'd0, 64'h1000, 0, 2'd3); chk_hit("R6 equal hit", 1, 0, 2);
        req(2'd0, 64'h1004, 0, 2'd3); chk_hit("R6 equal miss", 0, 0, 0);
        req(2'd1, 64'h1000, 0, 2'd3); chk_hit("R4 load not enabled", 0, 0, 0);
        req(2'd3, 64'h1000, 0, 2'd3); chk_hit("R4 op code 3", 0, 0, 0);
        set_trig(0, mk(2, 0, 0, 0, 4'b1000, 1, 0, 0), 64'h1000);
        req(2'd0, 64'h1000, 0, 2'd0); chk_hit("R4 priv 0 disabled", 0, 0, 0);
        req(2'd0, 64'h1000, 0, 2'd3); chk_hit("R4 priv 3 enabled", 1, 0, 2);
        set_trig(0, mk(0, 0, 0, 0, 4'hF, 1, 0, 0), 64'h1000);
        req(2'd0, 64'h1000, 0, 2'd3); chk_hit("R4 action 0 skipped", 0, 0, 0);
        clear_all();
    endtask

    task automatic t_data_sel();
        set_trig(1, mk(1, 0, 0, 1, 4'hF, 0, 0, 1), 64'hAB);
        req(2'd1, 64'hAB, 64'h0, 2'd1); chk_hit("R5 address ignored", 0, 0, 0);
        req(2'd1, 64'h0, 64'hAB, 2'd1); chk_hit("R5 data compared", 1, 1, 1);
        clear_all();
    endtask

    task automatic t_ordering();
        set_trig(0, mk(2, 2, 0, 0, 4'hF, 0, 1, 0), 64'h100);
        req(2'd2, 64'hFF, 0, 2'd3);  chk_hit("R6 ge below", 0, 0, 0);
        req(2'd2, 64'h100, 0, 2'd3); chk_hit("R6 ge equal", 1, 0, 2);
        set_trig(0, mk(2, 3, 0, 0, 4'hF, 0, 1, 0), 64'h100);
        req(2'd2, 64'hFF, 0, 2'd3);  chk_hit("R6 lt below", 1, 0, 2);
        req(2'd2, 64'h100, 0, 2'd3); chk_hit("R6 lt equal", 0, 0, 0);
        clear_all();
    endtask

    task automatic t_pow2();
        set_trig(0, mk(2, 1, 0, 0, 4'hF, 1, 0, 0), 64'h1007);
        req(2'd0, 64'h1000, 0, 2'd3); chk_hit("R7 base", 1, 0, 2);
        req(2'd0, 64'h1005, 0, 2'd3); chk_hit("R7 inside", 1, 0, 2);
        req(2'd0, 64'h1008, 0, 2'd3); chk_hit("R7 outside", 0, 0, 0);
        clear_all();
    endtask

    task automatic t_mask();
        set_trig(0, mk(2, 4, 0, 0, 4'hF, 1, 0, 0), 64'h0000_FF00_0000_1200);
        req(2'd0, 64'h12AB, 0, 2'd3);              chk_hit("R8 low hit", 1, 0, 2);
        req(2'd0, 64'hFFFF_0000_0000_12AB, 0, 2'd3); chk_hit("R8 low unmasked bits", 1, 0, 2);
        req(2'd0, 64'h13AB, 0, 2'd3);              chk_hit("R8 low miss", 0, 0, 0);
        set_trig(0, mk(2, 5, 0, 0, 4'hF, 1, 0, 0), 64'h0000_FF00_0000_1200);
        req(2'd0, 64'h0000_12CD_0000_0000, 0, 2'd3); chk_hit("R8 high hit", 1, 0, 2);
        req(2'd0, 64'h12CD, 0, 2'd3);              chk_hit("R8 high miss", 0, 0, 0);
        set_trig(0, mk(2, 6, 0, 0, 4'hF, 1, 0, 0), 64'h12CD);
        req(2'd0, 64'h12CD, 0, 2'd3);              chk_hit("R14 rule 6 silent", 0, 0, 0);
        set_trig(0, mk(2, 15, 0, 0, 4'hF, 1, 0, 0), 64'h12CD);
        req(2'd0, 64'h12CD, 0, 2'd3);              chk_hit("R14 rule 15 silent", 0, 0, 0);
        clear_all();
    endtask

    task automatic t_chain();
        set_trig(0, mk(2, 0, 0, 0, 4'hF, 1, 0, 0), 64'h40);
        set_trig(1, mk(3, 0, 1, 1, 4'hF, 1, 0, 0), 64'h99);
        req(2'd0, 64'h40, 64'h99, 2'd3); chk_hit("R9 pair completes", 1, 1, 3);
        req(2'd0, 64'h40, 64'h0, 2'd3);  chk_hit("R9 lower alone silent", 0, 0, 0);
        req(2'd0, 64'h41, 64'h99, 2'd3); chk_hit("R9 broken chain", 0, 0, 0);
        set_trig(2, mk(5, 0, 0, 0, 4'hF, 1, 0, 0), 64'h40);
        req(2'd0, 64'h40, 64'h0, 2'd3);  chk_hit("R10 independent trigger 2", 1, 2, 5);
        req(2'd0, 64'h40, 64'h99, 2'd3); chk_hit("R10 lowest completing", 1, 1, 3);
        clear_all();
        set_trig(0, mk(2, 0, 1, 0, 4'hF, 1, 0, 0), 64'h40);
        req(2'd0, 64'h40, 64'h0, 2'd3);  chk_hit("R9 chained trigger 0", 0, 0, 0);
        clear_all();
        set_trig(1, mk(4, 0, 0, 0, 4'hF, 1, 0, 0), 64'h80);
        set_trig(3, mk(5, 0, 0, 0, 4'hF, 1, 0, 0), 64'h80);
        req(2'd0, 64'h80, 64'h0, 2'd3);  chk_hit("R10 priority 1 over 3", 1, 1, 4);
        clear_all();
    endtask

    task automatic t_gating();
        set_trig(0, mk(2, 0, 0, 0, 4'hF, 1, 0, 0), 64'h2000);
        req(2'd0, 64'h2000, 0, 2'd3); chk_hit("R11 baseline", 1, 0, 2);
        dbg_active = 1'b1;
        req(2'd0, 64'h2000, 0, 2'd3); chk_hit("R11 debug active", 0, 0, 0);
        dbg_active = 1'b0;
        req(2'd0, 64'h2000, 0, 2'd3);
        req_valid = 1'b0; #1;
        chk_hit("R11 request not valid", 0, 0, 0);
        req_narrow = 1'b1;
        req(2'd0, 64'hFFFF_FFFF_0000_2000, 0, 2'd3); chk_hit("R12 narrow truncates", 1, 0, 2);
        req_narrow = 1'b0;
        req(2'd0, 64'hFFFF_FFFF_0000_2000, 0, 2'd3); chk_hit("R12 wide keeps upper", 0, 0, 0);
        clear_all();
    endtask

    task automatic t_arm();
        chk("R13 all clear", {arm_exec, arm_load, arm_store}, 0);
        wr(2'd0, 64'd2);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = 2'd1; csr_wdata = mk(1, 0, 0, 0, 4'hF, 0, 0, 1);
        #2 chk("R13 not before edge", 64'(arm_load), 0);
        @(negedge clk);
        csr_we = 1'b0;
        chk("R13 load armed", {arm_exec, arm_load, arm_store}, 3'b010);
        wr(2'd1, mk(0, 0, 0, 0, 4'hF, 0, 0, 1));
        chk("R13 action 0 disarms", {arm_exec, arm_load, arm_store}, 0);
        wr(2'd0, 64'd3);
        wr(2'd1, mk(4, 0, 0, 0, 4'hF, 1, 1, 0));
        chk("R13 store and exec armed", {arm_exec, arm_load, arm_store}, 3'b101);
        clear_all();
        chk("R13 cleared", {arm_exec, arm_load, arm_store}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_oob();
        t_filter();
        t_data_sel();
        t_ordering();
        t_pow2();
        t_mask();
        t_chain();
        t_gating();
        t_arm();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule